// File: doc/BRIEF.md
# IPv4 Header Check and Update

This block sits in a router datapath and inspects the IPv4 header of each packet as it streams past, one 32-bit word per beat, over a valid/ready channel with start-of-packet and last-beat markers. It sums the header checksum, validates version, header length, total length and word count, and reads the TTL. It then gives each packet one of three outcomes: forward on the hardware fast path, drop, or hand to the software exception path. Packets that arrive with an expiring TTL are also flagged so that software can build an ICMP reply.

The header words leave the block one register stage later. The third word carries TTL and checksum, and it is rewritten on the fly: TTL goes down by one and the checksum is adjusted incrementally. The rewrite needs only fields that are already known when that word passes, so no header buffering is needed. The outcome code leaves on the same beat as the last header word.

Top module: `ipv4_hdr_proc`

## Requirements
- R1: Word 0 holds version in bits [31:28], header length in 32-bit words in [27:24] and total length in bytes in [15:0]. Word 2 holds TTL in [31:24], protocol in [23:16] and checksum in [15:0]. Every word leaves on `out_data` in its arrival order. All words other than word 2 are unchanged.
- R2: The ones'-complement sum of all 16-bit halves of all received words must equal 0xFFFF. Otherwise the packet is dropped (code 01).
- R3: A version other than 4 sends the packet to the exception path (code 10). This rule overrides every other rule, including a bad checksum.
- R4: Word 2 is rewritten when all of these hold: version is 4, header length is exactly 5, total length is in range, and TTL is above 1. The rewrite still happens if the checksum later fails. The rewrite gives TTL minus one and an incrementally updated checksum. A computed checksum of 0x0000 is sent as 0xFFFF. A packet that passes every check is forwarded (code 00).
- R5: A TTL of 0 or 1 on an otherwise forwardable packet gives code 10 with `out_icmp` high on the last beat. Word 2 is then left unchanged.
- R6: A total length below 64 or above 1500 drops the packet (code 01). This rule ranks above the options and TTL rules.
- R7: A header length below 5, or a word count different from the header length, drops the packet. A header length above 5 (options present) with a good checksum gives code 10 without the ICMP flag. The full order of precedence is: version, then malformed length or count, then checksum, then total length, then options, then TTL.
- R8: The code appears on the beat with `out_last`, one cycle after the last input word is accepted when `out_ready` is high. Non-last beats carry code 00 and `out_icmp` low. Code 11 never appears.
- R9: While `out_ready` is low, a valid output beat holds all its fields stable and `in_ready` is low. No word is lost or duplicated.
- R10: During reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | DATA_W | Header word, first byte in the top bits |
| in_sop | input | 1 | First word of a packet |
| in_last | input | 1 | Last header word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DATA_W | Header word, possibly rewritten |
| out_sop | output | 1 | First word of a packet |
| out_last | output | 1 | Last header word, carries the code |
| out_verdict | output | 2 | 00 forward, 01 drop, 10 exception |
| out_icmp | output | 1 | TTL expiry, ICMP reply wanted |

## Verification
The assertions watch every cycle for three things: a stalled output beat must hold steady, code 11 must never appear, and the ICMP flag must appear only on a last beat that carries the exception code. A single-word packet must never be forwarded. Only the bench scenarios can show that the precedence order is right, that the rewritten checksum is correct (including the 0xFEFF input that yields 0xFFFF), that the one-cycle latency holds, and that no word is lost or duplicated under random stalls.

// File: rtl/ipv4_hdr_pkg.sv
package ipv4_hdr_pkg;

   typedef enum logic [1:0] {
      VERD_FWD  = 2'b00,
      VERD_DROP = 2'b01,
      VERD_EXC  = 2'b10
   } verdict_e;

   // ones'-complement 16-bit add with end-around carry
   function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'b0, s[16]};
   endfunction

endpackage

// File: rtl/ipv4_csum_acc.sv
module ipv4_csum_acc #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              restart,
   input  logic [DATA_W-1:0] word,
   output logic [15:0]       sum_with
);
   import ipv4_hdr_pkg::*;

   localparam int LANES = DATA_W / 16;

   logic [15:0] acc_q;
   logic [15:0] chain [LANES+1];

   assign chain[0] = restart ? 16'h0000 : acc_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign chain[g+1] = oc_add(chain[g], word[DATA_W-1-16*g -: 16]);
   end

   assign sum_with = chain[LANES];

   always_ff @(posedge clk) begin
      if (!rst_n)  acc_q <= 16'h0000;
      else if (en) acc_q <= chain[LANES];
   end

endmodule

// File: rtl/ipv4_ttl_rewrite.sv
module ipv4_ttl_rewrite #(
   parameter int DATA_W       = 32,
   parameter bit ZERO_AS_ONES = 1'b1
) (
   input  logic [DATA_W-1:0] word_in,
   output logic [DATA_W-1:0] word_out
);
   import ipv4_hdr_pkg::*;

   localparam logic [15:0] NEG_TTL_STEP = 16'hFEFF; // ones' complement of 0x0100

   logic [7:0]  ttl_old;
   logic [15:0] ck_old, ck_sum, ck_raw, ck_new;

   assign ttl_old = word_in[31:24];
   assign ck_old  = word_in[15:0];
   assign ck_sum  = oc_add(~ck_old, NEG_TTL_STEP);
   assign ck_raw  = ~ck_sum;

   if (ZERO_AS_ONES) begin : g_zero_map
      assign ck_new = (ck_raw == 16'h0000) ? 16'hFFFF : ck_raw;
   end else begin : g_zero_keep
      assign ck_new = ck_raw;
   end

   assign word_out = {ttl_old - 8'd1, word_in[23:16], ck_new};

endmodule

// File: rtl/ipv4_classify.sv
module ipv4_classify #(
   parameter int CNT_W      = 5,
   parameter int MIN_LEN    = 64,
   parameter int MAX_LEN    = 1500,
   parameter int BASE_WORDS = 5
) (
   input  logic [3:0]       ver,
   input  logic [3:0]       ihl,
   input  logic [15:0]      tot_len,
   input  logic [7:0]       ttl,
   input  logic [CNT_W:0]   nwords,
   input  logic             csum_ok,
   output logic [1:0]       verdict,
   output logic             icmp,
   output logic             may_rewrite
);
   import ipv4_hdr_pkg::*;

   localparam logic [3:0]  BASE4 = 4'(BASE_WORDS);
   localparam logic [15:0] MIN16 = 16'(MIN_LEN);
   localparam logic [15:0] MAX16 = 16'(MAX_LEN);

   logic ver_bad, malformed, len_bad, has_opts, ttl_low;
   verdict_e v;

   assign ver_bad   = (ver != 4'd4);
   assign malformed = (ihl < BASE4) || (nwords != (CNT_W+1)'(ihl));
   assign len_bad   = (tot_len < MIN16) || (tot_len > MAX16);
   assign has_opts  = (ihl > BASE4);
   assign ttl_low   = (ttl <= 8'd1);

   assign may_rewrite = !ver_bad && (ihl == BASE4) && !len_bad && !ttl_low;

   always_comb begin
      icmp = 1'b0;
      if (ver_bad)        v = VERD_EXC;
      else if (malformed) v = VERD_DROP;
      else if (!csum_ok)  v = VERD_DROP;
      else if (len_bad)   v = VERD_DROP;
      else if (has_opts)  v = VERD_EXC;
      else if (ttl_low) begin
         v    = VERD_EXC;
         icmp = 1'b1;
      end else            v = VERD_FWD;
   end

   assign verdict = v;

endmodule

// File: rtl/ipv4_hdr_proc.sv
module ipv4_hdr_proc #(
   parameter int DATA_W       = 32,
   parameter int MIN_LEN      = 64,
   parameter int MAX_LEN      = 1500,
   parameter int BASE_WORDS   = 5,
   parameter int CNT_W        = 5,
   parameter bit ZERO_AS_ONES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_last,
   output logic [1:0]        out_verdict,
   output logic              out_icmp
);
   import ipv4_hdr_pkg::*;

   localparam logic [CNT_W-1:0] IDX_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] IDX_TTL = CNT_W'(2);

   if (DATA_W != 32) begin : g_bad_width
      $error("ipv4_hdr_proc: DATA_W must be 32");
   end
   if (MIN_LEN > MAX_LEN || MAX_LEN > 65535) begin : g_bad_len
      $error("ipv4_hdr_proc: length window invalid");
   end
   if (CNT_W < 5) begin : g_bad_cnt
      $error("ipv4_hdr_proc: CNT_W must count past 15 words");
   end

   logic              fire;
   logic [CNT_W-1:0]  wcnt, idx;
   logic [CNT_W:0]    nwords;
   logic [3:0]        ver_q, ihl_q, h_ver, h_ihl;
   logic [15:0]       len_q, h_len;
   logic [7:0]        ttl_q, h_ttl;
   logic [15:0]       csum_total;
   logic              csum_ok;
   logic [1:0]        verd;
   logic              icmp, may_rw;
   logic [DATA_W-1:0] rw_word, next_word;

   assign in_ready = !out_valid || out_ready;
   assign fire     = in_valid && in_ready;
   assign idx      = in_sop ? '0 : wcnt;
   assign nwords   = {1'b0, idx} + (CNT_W+1)'(1);

   assign h_ver = (idx == '0) ? in_data[31:28] : ver_q;
   assign h_ihl = (idx == '0) ? in_data[27:24] : ihl_q;
   assign h_len = (idx == '0) ? in_data[15:0]  : len_q;
   assign h_ttl = (idx == IDX_TTL) ? in_data[31:24] : ttl_q;

   ipv4_csum_acc #(.DATA_W(DATA_W)) u_csum (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (fire),
      .restart  (idx == '0),
      .word     (in_data),
      .sum_with (csum_total)
   );

   assign csum_ok = (csum_total == 16'hFFFF);

   ipv4_classify #(
      .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .BASE_WORDS(BASE_WORDS)
   ) u_class (
      .ver         (h_ver),
      .ihl         (h_ihl),
      .tot_len     (h_len),
      .ttl         (h_ttl),
      .nwords      (nwords),
      .csum_ok     (csum_ok),
      .verdict     (verd),
      .icmp        (icmp),
      .may_rewrite (may_rw)
   );

   ipv4_ttl_rewrite #(.DATA_W(DATA_W), .ZERO_AS_ONES(ZERO_AS_ONES)) u_rw (
      .word_in  (in_data),
      .word_out (rw_word)
   );

   assign next_word = (idx == IDX_TTL && may_rw) ? rw_word : in_data;

   // header field capture and word counter
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt  <= '0;
         ver_q <= '0;
         ihl_q <= '0;
         len_q <= '0;
         ttl_q <= '0;
      end else if (fire) begin
         wcnt <= in_last ? '0 : ((idx == IDX_MAX) ? idx : idx + CNT_W'(1));
         if (idx == '0) begin
            ver_q <= in_data[31:28];
            ihl_q <= in_data[27:24];
            len_q <= in_data[15:0];
         end
         if (idx == IDX_TTL) ttl_q <= in_data[31:24];
      end
   end

   // output register stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         out_sop     <= 1'b0;
         out_last    <= 1'b0;
         out_verdict <= VERD_FWD;
         out_icmp    <= 1'b0;
      end else if (fire) begin
         out_valid   <= 1'b1;
         out_data    <= next_word;
         out_sop     <= (idx == '0);
         out_last    <= in_last;
         out_verdict <= in_last ? verd : VERD_FWD;
         out_icmp    <= in_last && icmp;
      end else if (out_ready) begin
         out_valid   <= 1'b0;
      end
   end

   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)
                                 && $stable(out_verdict) && $stable(out_icmp));

   assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_verdict != 2'b11);

   assert_icmp_exc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_icmp |-> out_last && out_verdict == VERD_EXC);

   assert_short_nofwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sop && out_last |-> out_verdict != VERD_FWD);

endmodule

// File: tb/test_ipv4_hdr_proc.sv
`timescale 1ns/1ps
module test_ipv4_hdr_proc;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_ready, in_sop, in_last;
   logic [31:0] in_data;
   logic        out_valid, out_ready, out_sop, out_last, out_icmp;
   logic [31:0] out_data;
   logic [1:0]  out_verdict;

   always #2 clk = ~clk;

   ipv4_hdr_proc i_ipv4_hdr_proc (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sop(in_sop), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_last(out_last),
      .out_verdict(out_verdict), .out_icmp(out_icmp)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // ver,ihl,nwords,len,ttl,bad,code,icmp,tag
   localparam int NVEC = 16;
   localparam logic [43:0] VEC [NVEC] = '{
      {4'd4,4'd5,4'd5,16'd100, 8'd64,1'b0,2'd0,1'b0,4'd4},
      {4'd4,4'd5,4'd5,16'd64,  8'd2, 1'b0,2'd0,1'b0,4'd6},
      {4'd4,4'd5,4'd5,16'd1500,8'd10,1'b0,2'd0,1'b0,4'd6},
      {4'd4,4'd5,4'd5,16'd63,  8'd10,1'b0,2'd1,1'b0,4'd6},
      {4'd4,4'd5,4'd5,16'd1501,8'd10,1'b0,2'd1,1'b0,4'd6},
      {4'd4,4'd5,4'd5,16'd100, 8'd64,1'b1,2'd1,1'b0,4'd2},
      {4'd6,4'd5,4'd5,16'd100, 8'd64,1'b0,2'd2,1'b0,4'd3},
      {4'd6,4'd5,4'd5,16'd100, 8'd64,1'b1,2'd2,1'b0,4'd3},
      {4'd4,4'd6,4'd6,16'd100, 8'd64,1'b0,2'd2,1'b0,4'd7},
      {4'd4,4'd6,4'd6,16'd100, 8'd64,1'b1,2'd1,1'b0,4'd7},
      {4'd4,4'd5,4'd5,16'd100, 8'd1, 1'b0,2'd2,1'b1,4'd5},
      {4'd4,4'd5,4'd5,16'd100, 8'd0, 1'b0,2'd2,1'b1,4'd5},
      {4'd4,4'd5,4'd4,16'd100, 8'd64,1'b0,2'd1,1'b0,4'd7},
      {4'd4,4'd4,4'd4,16'd100, 8'd64,1'b0,2'd1,1'b0,4'd7},
      {4'd4,4'd5,4'd5,16'd40,  8'd1, 1'b0,2'd1,1'b0,4'd6},
      {4'd4,4'd6,4'd6,16'd100, 8'd1, 1'b0,2'd2,1'b0,4'd7}
   };

   function automatic string tagname(input logic [3:0] t);
      case (t)
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [15:0] oca(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'b0, s[16]};
   endfunction

   logic [31:0] hw [16];
   int          hn;

   task automatic build(input logic [3:0] ver, input logic [3:0] ihl, input int nw,
                        input logic [15:0] len, input logic [7:0] ttl,
                        input logic [15:0] id, input bit bad);
      logic [15:0] s;
      hn = nw;
      for (int i = 0; i < 16; i++) hw[i] = 32'h01010101;
      hw[0] = {ver, ihl, 8'h00, len};
      hw[1] = {id, 16'h4000};
      hw[2] = {ttl, 8'h06, 16'h0000};
      hw[3] = 32'h0A000001;
      hw[4] = 32'hC0A80102;
      s = 16'h0000;
      for (int i = 0; i < nw; i++) begin
         s = oca(s, hw[i][31:16]);
         s = oca(s, hw[i][15:0]);
      end
      hw[2][15:0] = ~s ^ (bad ? 16'h0001 : 16'h0000);
   endtask

   logic [31:0] ex_data [1024];
   logic        ex_last [1024];
   logic [1:0]  ex_code [1024];
   logic        ex_icmp [1024];
   string       ex_tag  [1024];
   int          wp = 0, rp = 0;
   int          last_in_cyc = 0, last_out_cyc = 0;

   task automatic send(input logic [1:0] code, input bit icmp, input string tag);
      logic [3:0]  ver, ihl;
      logic [15:0] len, ck;
      logic [7:0]  ttl;
      bit          rw;
      ver = hw[0][31:28]; ihl = hw[0][27:24]; len = hw[0][15:0]; ttl = hw[2][31:24];
      rw  = (ver == 4'd4) && (ihl == 4'd5) && (len >= 16'd64) && (len <= 16'd1500) && (ttl > 8'd1);
      for (int i = 0; i < hn; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = hw[i];
         in_sop   = (i == 0);
         in_last  = (i == hn - 1);
         ex_data[wp] = hw[i];
         if (i == 2 && rw) begin
            ck = oca(hw[2][15:0], 16'h0100);
            if (ck == 16'h0000) ck = 16'hFFFF;
            ex_data[wp] = {ttl - 8'd1, hw[2][23:16], ck};
         end
         ex_last[wp] = (i == hn - 1);
         ex_code[wp] = (i == hn - 1) ? code : 2'b00;
         ex_icmp[wp] = (i == hn - 1) ? icmp : 1'b0;
         ex_tag[wp]  = tag;
         wp++;
         #1;
         while (!in_ready) begin
            @(negedge clk);
            #1;
         end
         if (i == hn - 1) last_in_cyc = cyc;
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0; in_data = 32'h0;
   endtask

   // output ready generation
   bit          stall_mode = 1'b0, force_low = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = force_low ? 1'b0 : (stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1);
   end

   // output monitor
   always @(negedge clk) begin
      #1;
      if (rst_n && out_valid && out_ready) begin
         if (rp >= wp) chk(1'b0, "R9", "unexpected extra word", out_data, 32'h0);
         else begin
            chk(out_data == ex_data[rp], (ex_tag[rp] == "R4") ? "R4" : "R1",
                $sformatf("word data (%s pkt)", ex_tag[rp]), out_data, ex_data[rp]);
            chk(out_last == ex_last[rp], "R1", "last marker", 32'(out_last), 32'(ex_last[rp]));
            if (ex_last[rp]) begin
               chk(out_verdict == ex_code[rp], ex_tag[rp], "verdict", 32'(out_verdict), 32'(ex_code[rp]));
               chk(out_icmp == ex_icmp[rp], ex_tag[rp], "icmp flag", 32'(out_icmp), 32'(ex_icmp[rp]));
               last_out_cyc = cyc;
            end else begin
               chk(out_verdict == 2'b00 && !out_icmp, "R8", "non-last beat code",
                   {29'b0, out_icmp, out_verdict}, 32'h0);
            end
            rp++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   task automatic run_vectors();
      for (int v = 0; v < NVEC; v++) begin
         build(VEC[v][43:40], VEC[v][39:36], int'(VEC[v][35:32]), VEC[v][31:16],
               VEC[v][15:8], 16'h1234, VEC[v][7]);
         send(VEC[v][6:5], VEC[v][4], tagname(VEC[v][3:0]));
      end
      idle();
   endtask

   logic [31:0] held;
   logic [15:0] c0;

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0; in_data = 32'h0;
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R10", "out_valid in reset", 32'(out_valid), 32'h0);
      chk(in_ready == 1'b1, "R10", "in_ready in reset", 32'(in_ready), 32'h1);
      @(negedge clk); rst_n = 1'b1;

      // table walk, no stalls
      run_vectors();
      repeat (4) @(negedge clk);

      // latency with free output
      build(4'd4, 4'd5, 5, 16'd200, 8'd33, 16'h0042, 1'b0);
      send(2'b00, 1'b0, "R8");
      idle();
      repeat (3) @(negedge clk);
      chk(last_out_cyc - last_in_cyc == 1, "R8", "verdict latency",
          32'(last_out_cyc - last_in_cyc), 32'd1);

      // checksum that rewrites to 0x0000, sent as 0xFFFF
      build(4'd4, 4'd5, 5, 16'd100, 8'd64, 16'h0000, 1'b0);
      c0 = hw[2][15:0];
      build(4'd4, 4'd5, 5, 16'd100, 8'd64, oca(16'h0100, c0), 1'b0);
      chk(hw[2][15:0] == 16'hFEFF, "R4", "setup checksum", 32'(hw[2][15:0]), 32'h0000FEFF);
      send(2'b00, 1'b0, "R4");
      idle();
      repeat (3) @(negedge clk);
      chk(ex_data[wp-3][15:0] == 16'hFFFF, "R4", "expected zero mapped",
          32'(ex_data[wp-3][15:0]), 32'h0000FFFF);

      // held output under backpressure
      force_low = 1'b1;
      build(4'd4, 4'd5, 5, 16'd300, 8'd9, 16'h0777, 1'b0);
      fork
         send(2'b00, 1'b0, "R4");
      join_none
      repeat (4) @(negedge clk);
      #1;
      held = out_data;
      chk(out_valid && !in_ready, "R9", "stall valid/ready",
          {30'b0, out_valid, in_ready}, 32'h2);
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid && out_data == held, "R9", "stall data stable", out_data, held);
      force_low = 1'b0;
      wait fork;
      idle();
      repeat (6) @(negedge clk);

      // table walk under random stalls
      stall_mode = 1'b1;
      run_vectors();
      stall_mode = 1'b0;
      repeat (10) @(negedge clk);
      chk(rp == wp, "R9", "all words delivered", 32'(rp), 32'(wp));

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule